// File: doc/BRIEF.md
# Paced Buffer DMA Engine

This block moves bytes from a 16 KiB byte buffer, held outside the block, to a downstream consumer. Each byte is spaced by a fixed number of clock cycles. A host writes a start address and a 16-bit count, then fires a trigger while data output is enabled. From then on the engine offers one byte at a time on a valid/ready port. The buffer address is presented on `rd_addr`, and the byte returns combinationally on `rd_data`.

A 3-bit destination code sits in a control word. It sets the spacing between bytes: 84 cycles when the code selects sample RAM (code 4), and 24 cycles for every other code. Both values come from a base step of four clocks (two cascaded divide-by-2 stages) times a multiplier of 6 or 21.

If the consumer refuses a byte, the engine pauses and keeps its place. A later control write that moves the code from a non-transfer code to a transfer-capable code restarts it at the same byte. Each control write also clears a destination address counter, which counts the accepted bytes.

Top module: `paced_buf_dma`

## Requirements
- R1: After reset `busy_n` is 1, `done` is 0, `snk_valid` is 0, `rd_addr` is 0, `dst_addr` is 0 and `snk_dest` is 0.
- R2: A `trig` pulse while `out_en` is 1 does four things: it drives `busy_n` low, clears `done`, and loads the staged count and start address. It also raises `snk_valid` in the following cycle. A `trig` while `out_en` is 0 has no effect.
- R3: With `snk_ready` held high and any destination code other than 4, accepted bytes are exactly 24 cycles apart.
- R4: With destination code 4, accepted bytes are exactly 84 cycles apart.
- R5: `snk_data` equals `rd_data`. Each accepted byte advances `rd_addr` by one, modulo 16384, so address 0x3FFF is followed by 0x0000.
- R6: The count is a low byte and a high byte. The low byte decrements on every accepted byte, and the high byte decrements when the low byte wraps from 0x00 to 0xFF. A count of N moves N+1 bytes. After the last byte, `done` is 1, `busy_n` is 1 and `snk_valid` stays 0.
- R7: A byte offered with `snk_ready` low pauses the transfer. `snk_valid` drops in the next cycle, and neither the address nor the count changes.
- R8: In a pause, a control write that changes the code from a non-transfer code (0, 1 or 6) to a transfer code (2, 3, 4, 5 or 7) raises `snk_valid` in the next cycle at the same address. Any other change of code leaves the pause in place.
- R9: The destination code is taken from bits 10:8 of `ctrl_wdata` and shown on `snk_dest`. The other bits are ignored.
- R10: `dst_addr` increments on every accepted byte and clears on every control write. A clear wins over an increment in the same cycle.
- R11: A change of code during a transfer keeps the timing of the byte already being paced. The new spacing applies from the byte after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Stage `cfg_start` and `cfg_count` |
| cfg_start | input | 14 | Start address in the buffer |
| cfg_count | input | 16 | Byte count minus one |
| out_en | input | 1 | Data output enable; qualifies `trig` |
| trig | input | 1 | Transfer start pulse |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; destination code in bits 10:8 |
| rd_addr | output | 14 | Buffer read address |
| rd_data | input | 8 | Buffer byte at `rd_addr` |
| snk_valid | output | 1 | Byte offered to the consumer |
| snk_data | output | 8 | Offered byte |
| snk_dest | output | 3 | Current destination code |
| snk_ready | input | 1 | Consumer accepts the offered byte |
| dst_addr | output | 16 | Destination byte counter |
| busy_n | output | 1 | Low while a transfer is loaded |
| done | output | 1 | Set when the count runs out, cleared by a trigger |

## Verification
Two functions can fall in the same cycle: a control write, and the acceptance of a byte. The write clears `dst_addr`, while the acceptance would increment it and also reload the pacing timer under the code that is still registered. The bench provokes this by waiting until `snk_valid` is high and then writing the control word in that same cycle. It expects `dst_addr` to read 0 afterwards while `rd_addr` still advances by one. A second test writes a new code one cycle after an acceptance and checks that the gap already running keeps 24 cycles and only the next gap becomes 84.

// File: rtl/pbd_pkg.sv
// Package: shared state type and destination classification for the
// paced buffer DMA engine. Assumes a 3-bit destination code.
package pbd_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_RUN   = 2'd1,
        XS_PAUSE = 2'd2
    } xfer_state_e;

    localparam int DEST_W = 3;

    // True when the code names a destination that can take DMA data.
    function automatic logic dest_is_dma(input logic [DEST_W-1:0] code,
                                         input logic [DEST_W-1:0] first_dma,
                                         input logic [DEST_W-1:0] excluded);
        return (code >= first_dma) && (code != excluded);
    endfunction

endpackage

// File: rtl/pbd_pacer.sv
// Module: per-byte pacing timer. Reports "due" when the next byte may be
// offered. Arm forces due at once; an accepted byte reloads the timer
// with the period chosen by slow at that cycle. Assumes periods >= 2.
module pbd_pacer #(
    parameter int STD_PERIOD = 24,
    parameter int PCM_PERIOD = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fire,
    input  logic slow,
    output logic due
);
    localparam int MAXP = (STD_PERIOD > PCM_PERIOD) ? STD_PERIOD : PCM_PERIOD;
    localparam int PW   = $clog2(MAXP + 1);
    localparam logic [PW-1:0] STD_RL = PW'(STD_PERIOD - 1);
    localparam logic [PW-1:0] PCM_RL = PW'(PCM_PERIOD - 1);

    logic [PW-1:0] wait_q;

    // Count down the cycles left before the next byte may be offered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= '0;
        else if (arm)
            wait_q <= '0;
        else if (fire)
            wait_q <= slow ? PCM_RL : STD_RL;
        else if (wait_q != '0)
            wait_q <= wait_q - 1'b1;
    end

    assign due = (wait_q == '0);
endmodule

// File: rtl/pbd_cursor.sv
// Module: buffer read address and remaining byte count. The count is kept
// as a low and a high byte; the high byte borrows when the low byte wraps.
// Assumes CNT_W > 8.
module pbd_cursor #(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int LO_W = 8;
    localparam int HI_W = CNT_W - LO_W;

    logic [LO_W-1:0] cnt_lo;
    logic [HI_W-1:0] cnt_hi;

    // Load on trigger; step address and count on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (load) begin
            addr   <= start_addr;
            cnt_lo <= start_count[LO_W-1:0];
            cnt_hi <= start_count[CNT_W-1:LO_W];
        end else if (step) begin
            addr   <= addr + 1'b1;
            cnt_lo <= cnt_lo - 1'b1;
            if (cnt_lo == '0)
                cnt_hi <= cnt_hi - 1'b1;
        end
    end

    assign last = (cnt_lo == '0) && (cnt_hi == '0);
endmodule

// File: rtl/pbd_dest_reg.sv
// Module: destination code register and destination byte counter. Flags a
// resume request when a control write moves the code from a non-DMA code
// to a DMA code. Assumes the code sits in bits 10:8 of the control word.
module pbd_dest_reg
    import pbd_pkg::*;
#(
    parameter int DST_AW    = 16,
    parameter int DEST_MAIN = 2,
    parameter int DEST_SKIP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    input  logic              fire,
    output logic [DEST_W-1:0] dest,
    output logic [DST_AW-1:0] dst_addr,
    output logic              resume_req
);
    localparam logic [DEST_W-1:0] MAIN_C = DEST_W'(DEST_MAIN);
    localparam logic [DEST_W-1:0] SKIP_C = DEST_W'(DEST_SKIP);

    logic [DEST_W-1:0] new_code;
    assign new_code = ctrl_wdata[10:8];

    // Hold the destination code written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dest <= '0;
        else if (ctrl_we)
            dest <= new_code;
    end

    // Count accepted bytes; any control write clears the count first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dst_addr <= '0;
        else if (ctrl_we)
            dst_addr <= '0;
        else if (fire)
            dst_addr <= dst_addr + 1'b1;
    end

    assign resume_req = ctrl_we
                        && !dest_is_dma(dest, MAIN_C, SKIP_C)
                        && dest_is_dma(new_code, MAIN_C, SKIP_C);
endmodule

// File: rtl/paced_buf_dma.sv
// Module: paced buffer DMA engine top. Offers bytes from an external 16 KiB
// buffer to a valid/ready consumer at a per-destination pace, pauses on
// refusal and resumes on a switch to a DMA destination. Assumes rd_data
// is the buffer byte at rd_addr in the same cycle.
module paced_buf_dma
    import pbd_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int CNT_W     = 16,
    parameter int DST_AW    = 16,
    parameter int EXT_DIV   = 2,
    parameter int INT_DIV   = 2,
    parameter int MULT_STD  = 6,
    parameter int MULT_PCM  = 21,
    parameter int DEST_MAIN = 2,
    parameter int DEST_PCM  = 4,
    parameter int DEST_SKIP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              out_en,
    input  logic              trig,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              snk_valid,
    output logic [7:0]        snk_data,
    output logic [2:0]        snk_dest,
    input  logic              snk_ready,
    output logic [DST_AW-1:0] dst_addr,
    output logic              busy_n,
    output logic              done
);
    localparam int STEP       = EXT_DIV * INT_DIV;
    localparam int STD_PERIOD = STEP * MULT_STD;
    localparam int PCM_PERIOD = STEP * MULT_PCM;
    localparam logic [DEST_W-1:0] PCM_C = DEST_W'(DEST_PCM);

    xfer_state_e       state;
    logic [ADDR_W-1:0] stage_addr;
    logic [CNT_W-1:0]  stage_count;
    logic              start, fire, refuse, last, due, resume_req, arm;
    logic [DEST_W-1:0] dest;

    assign start  = trig && out_en;
    assign fire   = snk_valid && snk_ready;
    assign refuse = snk_valid && !snk_ready;
    assign arm    = start || ((state == XS_PAUSE) && resume_req);

    // Stage start address and count until the next trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_addr  <= '0;
            stage_count <= '0;
        end else if (cfg_we) begin
            stage_addr  <= cfg_start;
            stage_count <= cfg_count;
        end
    end

    // Transfer sequencing: idle, running, or paused on a refusal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= XS_IDLE;
        else if (start)
            state <= XS_RUN;
        else begin
            case (state)
                XS_RUN:   if (fire && last) state <= XS_IDLE;
                          else if (refuse)  state <= XS_PAUSE;
                XS_PAUSE: if (resume_req)   state <= XS_RUN;
                default:  state <= state;
            endcase
        end
    end

    // Busy and end-of-transfer status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n <= 1'b1;
            done   <= 1'b0;
        end else if (start) begin
            busy_n <= 1'b0;
            done   <= 1'b0;
        end else if (fire && last) begin
            busy_n <= 1'b1;
            done   <= 1'b1;
        end
    end

    pbd_pacer #(
        .STD_PERIOD (STD_PERIOD),
        .PCM_PERIOD (PCM_PERIOD)
    ) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .fire  (fire),
        .slow  (dest == PCM_C),
        .due   (due)
    );

    pbd_cursor #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .start_addr  (stage_addr),
        .start_count (stage_count),
        .step        (fire),
        .addr        (rd_addr),
        .last        (last)
    );

    pbd_dest_reg #(
        .DST_AW    (DST_AW),
        .DEST_MAIN (DEST_MAIN),
        .DEST_SKIP (DEST_SKIP)
    ) u_dest (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .fire       (fire),
        .dest       (dest),
        .dst_addr   (dst_addr),
        .resume_req (resume_req)
    );

    assign snk_valid = (state == XS_RUN) && due;
    assign snk_data  = rd_data;
    assign snk_dest  = dest;
endmodule

// File: rtl/pbd_checker.sv
// Module: protocol checker for paced_buf_dma, attached by bind. Observes
// ports only. Assumes the default 14-bit address.
module pbd_checker #(
    parameter int ADDR_W = 14,
    parameter int DST_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              out_en,
    input logic              ctrl_we,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic [DST_AW-1:0] dst_addr,
    input logic              busy_n,
    input logic              done
);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && out_en) |=> (!busy_n && !done));

    a_r2_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> !busy_n);

    a_r3_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && snk_ready && !(trig && out_en)) |=> !snk_valid);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && snk_ready && !(trig && out_en))
        |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_n && !snk_valid));

    a_r7_refusal_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready && !(trig && out_en))
        |=> (!snk_valid && $stable(rd_addr)));

    a_r10_dst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (dst_addr == '0));
endmodule

bind paced_buf_dma pbd_checker #(.ADDR_W(ADDR_W), .DST_AW(DST_AW)) u_pbd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .out_en    (out_en),
    .ctrl_we   (ctrl_we),
    .rd_addr   (rd_addr),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready),
    .dst_addr  (dst_addr),
    .busy_n    (busy_n),
    .done      (done)
);

// File: tb/tb_paced_buf_dma.sv
module tb_paced_buf_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_start = '0;
    logic [15:0] cfg_count = '0;
    logic        out_en = 1'b0;
    logic        trig = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [13:0] rd_addr;
    logic [7:0]  rd_data;
    logic        snk_valid;
    logic [7:0]  snk_data;
    logic [2:0]  snk_dest;
    logic        rdy = 1'b1;
    logic [15:0] dst_addr;
    logic        busy_n;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_acc = 0;
    int acc_cyc  [0:511];
    int acc_addr [0:511];
    int acc_data [0:511];

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b01};
    endfunction

    assign rd_data = pat(rd_addr);

    paced_buf_dma dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .cfg_count(cfg_count), .out_en(out_en), .trig(trig),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .snk_valid(snk_valid), .snk_data(snk_data),
        .snk_dest(snk_dest), .snk_ready(rdy), .dst_addr(dst_addr),
        .busy_n(busy_n), .done(done)
    );

    // Consumer model: log every accepted byte with its cycle and address.
    always @(posedge clk) begin
        if (snk_valid && rdy && n_acc < 512) begin
            acc_cyc[n_acc]  <= cyc;
            acc_addr[n_acc] <= int'(rd_addr);
            acc_data[n_acc] <= int'(snk_data);
            n_acc <= n_acc + 1;
        end
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [13:0] a, input logic [15:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_start = a; cfg_count = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_ctrl(input logic [15:0] w);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Pulse the trigger; returns the cycle stamp at which it was driven.
    task automatic fire_trig(output int tc);
        @(negedge clk);
        trig = 1'b1; tc = cyc;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(snk_valid == 1'b0, "R1 valid", snk_valid, 0);
        chk(rd_addr == 0, "R1 rd_addr", rd_addr, 0);
        chk(dst_addr == 0, "R1 dst_addr", dst_addr, 0);
        chk(snk_dest == 0, "R1 dest", snk_dest, 0);
    endtask

    task automatic t_std_pacing();
        int tc, b;
        write_ctrl(16'h0200);
        write_cfg(14'h0010, 16'd3);
        b = n_acc;
        fire_trig(tc);
        wait_done(400);
        @(negedge clk);
        chk(n_acc - b == 4, "R6 byte count N+1", n_acc - b, 4);
        chk(acc_cyc[b] == tc + 1, "R2 first byte next cycle", acc_cyc[b], tc + 1);
        for (int i = 1; i < 4; i++)
            chk(acc_cyc[b+i] - acc_cyc[b+i-1] == 24, "R3 gap", acc_cyc[b+i] - acc_cyc[b+i-1], 24);
        for (int i = 0; i < 4; i++) begin
            chk(acc_addr[b+i] == 16 + i, "R5 address", acc_addr[b+i], 16 + i);
            chk(acc_data[b+i] == int'(pat(14'(16 + i))), "R5 data", acc_data[b+i], int'(pat(14'(16 + i))));
        end
        chk(done && busy_n, "R6 done and busy_n", {done, busy_n}, 3);
        chk(dst_addr == 4, "R10 dst_addr count", dst_addr, 4);
    endtask

    task automatic t_pcm_pacing();
        int tc, b;
        write_ctrl(16'h0400);
        write_cfg(14'h0100, 16'd2);
        b = n_acc;
        fire_trig(tc);
        wait_done(600);
        @(negedge clk);
        chk(n_acc - b == 3, "R4 bytes", n_acc - b, 3);
        for (int i = 1; i < 3; i++)
            chk(acc_cyc[b+i] - acc_cyc[b+i-1] == 84, "R4 gap", acc_cyc[b+i] - acc_cyc[b+i-1], 84);
    endtask

    task automatic t_trig_disabled();
        int tc, b;
        out_en = 1'b0;
        b = n_acc;
        fire_trig(tc);
        repeat (5) @(negedge clk);
        chk(busy_n == 1'b1, "R2 ignored trigger busy_n", busy_n, 1);
        chk(n_acc == b, "R2 ignored trigger bytes", n_acc - b, 0);
        chk(done == 1'b1, "R2 ignored trigger done kept", done, 1);
        out_en = 1'b1;
    endtask

    task automatic t_stall_resume();
        int tc, b, wc;
        write_ctrl(16'h0200);
        write_cfg(14'h0200, 16'd5);
        rdy = 1'b0;
        b = n_acc;
        fire_trig(tc);
        repeat (4) @(negedge clk);
        chk(snk_valid == 1'b0, "R7 paused valid", snk_valid, 0);
        chk(rd_addr == 14'h0200, "R7 address held", rd_addr, 'h200);
        chk(busy_n == 1'b0, "R7 still busy", busy_n, 0);
        rdy = 1'b1;
        write_ctrl(16'h0300);
        repeat (3) @(negedge clk);
        chk(snk_valid == 1'b0 && n_acc == b, "R8 dma to dma no resume", snk_valid, 0);
        write_ctrl(16'h0000);
        write_ctrl(16'h0100);
        repeat (3) @(negedge clk);
        chk(n_acc == b, "R8 non-dma to non-dma no resume", n_acc - b, 0);
        write_ctrl(16'h0600);
        repeat (3) @(negedge clk);
        chk(n_acc == b, "R8 code 6 no resume", n_acc - b, 0);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 16'h0500; wc = cyc;
        @(negedge clk);
        ctrl_we = 1'b0;
        wait_done(600);
        @(negedge clk);
        chk(acc_cyc[b] == wc + 1, "R8 resume next cycle", acc_cyc[b], wc + 1);
        chk(acc_addr[b] == 'h200, "R8 resume same address", acc_addr[b], 'h200);
        chk(n_acc - b == 6, "R6 bytes after stall", n_acc - b, 6);
        chk(dst_addr == 6, "R10 dst_addr after writes", dst_addr, 6);
    endtask

    task automatic t_wrap();
        int tc, b;
        write_ctrl(16'h0200);
        write_cfg(14'h3FFE, 16'd3);
        b = n_acc;
        fire_trig(tc);
        wait_done(400);
        @(negedge clk);
        chk(acc_addr[b+1] == 'h3FFF, "R5 before wrap", acc_addr[b+1], 'h3FFF);
        chk(acc_addr[b+2] == 0, "R5 wrap to zero", acc_addr[b+2], 0);
        chk(acc_addr[b+3] == 1, "R5 after wrap", acc_addr[b+3], 1);
    endtask

    task automatic t_borrow();
        int tc, b;
        write_ctrl(16'h0200);
        write_cfg(14'h0000, 16'h0100);
        b = n_acc;
        fire_trig(tc);
        wait_done(8000);
        @(negedge clk);
        chk(n_acc - b == 257, "R6 high byte borrow count", n_acc - b, 257);
        chk(acc_addr[b+256] == 'h100, "R6 last address", acc_addr[b+256], 'h100);
        chk(done == 1'b1, "R6 done after borrow", done, 1);
    endtask

    task automatic t_pace_change();
        int tc, b;
        write_ctrl(16'h0200);
        write_cfg(14'h0040, 16'd3);
        b = n_acc;
        fire_trig(tc);
        while (n_acc - b < 2) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 16'hFCFF;   // code 4 in bits 10:8, noise elsewhere
        @(negedge clk);
        ctrl_we = 1'b0;
        chk(snk_dest == 3'd4, "R9 code from bits 10:8", snk_dest, 4);
        wait_done(600);
        @(negedge clk);
        chk(acc_cyc[b+2] - acc_cyc[b+1] == 24, "R11 pending gap kept", acc_cyc[b+2] - acc_cyc[b+1], 24);
        chk(acc_cyc[b+3] - acc_cyc[b+2] == 84, "R11 new gap", acc_cyc[b+3] - acc_cyc[b+2], 84);
    endtask

    task automatic t_collide();
        int tc;
        logic [13:0] a0;
        write_ctrl(16'h0200);
        write_cfg(14'h0080, 16'd3);
        fire_trig(tc);
        while (n_acc == 0 || !snk_valid) @(negedge clk);
        while (!snk_valid) @(negedge clk);
        a0 = rd_addr;
        ctrl_we = 1'b1; ctrl_wdata = 16'h0200;
        @(negedge clk);
        ctrl_we = 1'b0;
        chk(dst_addr == 0, "R10 clear beats increment", dst_addr, 0);
        chk(rd_addr == a0 + 1'b1, "R10 byte still taken", rd_addr, a0 + 1);
        wait_done(400);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog: cycle %0d expected below %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        out_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_pacing();
        t_trig_disabled();
        t_pcm_pacing();
        t_stall_resume();
        t_wrap();
        t_borrow();
        t_pace_change();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule